// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block lets a host processor issue one PCIe configuration read or write at a time through a small 32-bit register bus. Software programs a transaction type, a packed configuration address, write data and a byte strobe, and then sets the start bit. The engine copies those settings when it launches. It presents the request on a valid/ready port and then waits for a single-cycle completion.

When the completion arrives, the engine clears the start bit and sets the interrupt flag. It records the 3-bit completion code and, for reads, the returned dword. If no completion arrives within a parameterised number of cycles, the engine withdraws the request and finishes on its own. In that case it reports a completer abort and all-ones read data.

Software packs the address and computes the strobe. It also extracts sub-dword read results. The engine carries these values to and from the port unchanged.

Top module: `cfgpio_engine`

## Requirements
- R1: After reset every register reads 0, start reads 0, the interrupt flag reads 0 and `req_valid` is low.
- R2: The register word offsets are: control 0, status 1, address low 2, address high 3, write data 4, strobe 5, read data 6, start 7, interrupt 8. Control, both address words and write data read back exactly as written. The strobe register keeps bits 3:0.
- R3: Writing start with bit 0 set while idle raises `req_valid` on the next cycle, and start then reads 1. The request carries the settings latched at launch: type = control[3:0], window bypass = control[24], address = {address high, address low}, write data and strobe.
- R4: While `req_ready` is low, `req_valid` stays high and every request field stays stable. `req_valid` falls in the cycle after the handshake.
- R5: A start write during a transfer is ignored. It causes no second request. Rewriting the control, address, data or strobe registers during a transfer does not change the request in flight.
- R6: A completion accepted while the engine waits finishes the transfer. On the next cycle start reads 0, interrupt bit 0 reads 1 and status bits 9:7 hold the completion code (0 success, 1 unsupported, 2 retry, 4 abort).
- R7: For read types (type bit 1 = 0, codes 0x8 and 0x9), read data takes the completion data. For write types (0xA and 0xB), read data keeps its previous value.
- R8: Status bit 0 holds the non-posted flag, which is bit 3 of the launched type. Configuration types 0x8 to 0xB set it.
- R9: If no completion arrives by the TIMEOUT_CYCLES-th clock after launch, the transfer ends at that clock. Any pending request is withdrawn, the status code is 4 and read data is 0xFFFFFFFF.
- R10: Writing 1 to interrupt bit 0 clears it. Writing 0 leaves it set.
- R11: `cpl_valid` is ignored while idle and while the request has not yet been accepted.
- R12: The address low word reaches the port unchanged. A packed address of bus in bits 27:20, device in 19:15, function in 14:12 and register offset in 11:2 appears intact. A sub-dword write's shifted data (data << 8*offset) and strobe (size ones << offset) also pass through intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted |
| req_type | output | 4 | Latched transaction type |
| req_win_bypass | output | 1 | Skip address-window translation |
| req_addr | output | 64 | Latched request address |
| req_wdata | output | 32 | Latched write data |
| req_strb | output | 4 | Latched byte strobe |
| cpl_valid | input | 1 | Completion present (one cycle) |
| cpl_status | input | 3 | Completion code |
| cpl_data | input | 32 | Completion read data |

## Verification
The bench builds the engine with TIMEOUT_CYCLES set to 20 instead of the default 1024. This lets it count the exact clock on which an unanswered transfer gives up, and check that the request is still held one cycle earlier. The short window also leaves room for long `req_ready` stalls and busy-time rewrites in the directed runs, which still finish well inside the timeout. The register address width stays at its default of 4, which covers all nine registers.

// File: rtl/cfgpio_pkg.sv
package cfgpio_pkg;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    localparam logic [3:0] OFF_CTRL = 4'd0;
    localparam logic [3:0] OFF_STAT = 4'd1;
    localparam logic [3:0] OFF_ADLO = 4'd2;
    localparam logic [3:0] OFF_ADHI = 4'd3;
    localparam logic [3:0] OFF_WDAT = 4'd4;
    localparam logic [3:0] OFF_STRB = 4'd5;
    localparam logic [3:0] OFF_RDAT = 4'd6;
    localparam logic [3:0] OFF_GO   = 4'd7;
    localparam logic [3:0] OFF_IRQ  = 4'd8;

    localparam logic [2:0] CODE_ABORT = 3'd4;
    localparam int BYPASS_BIT = 24;

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_e;

    typedef struct packed {
        logic [3:0]      kind;
        logic            bypass;
        logic [2*DW-1:0] addr;
        logic [DW-1:0]   wdata;
        logic [SW-1:0]   strb;
    } cfg_req_t;
endpackage

// File: rtl/cfgpio_regs.sv
module cfgpio_regs
    import cfgpio_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          done,
    input  logic          done_timeout,
    input  logic [2:0]    done_status,
    input  logic [DW-1:0] done_data,
    input  logic [3:0]    done_kind,
    output logic          go,
    output cfg_req_t      shadow
);
    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] adlo;
        logic [DW-1:0] adhi;
        logic [DW-1:0] wdat;
        logic [SW-1:0] strb;
        logic [2:0]    code;
        logic          nonposted;
        logic [DW-1:0] rdat;
        logic          irq;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        go    = 1'b0;
        if (wr_en) begin
            case (addr)
                AW'(OFF_CTRL): reg_d.ctrl = wdata;
                AW'(OFF_ADLO): reg_d.adlo = wdata;
                AW'(OFF_ADHI): reg_d.adhi = wdata;
                AW'(OFF_WDAT): reg_d.wdat = wdata;
                AW'(OFF_STRB): reg_d.strb = wdata[SW-1:0];
                AW'(OFF_GO):   go = wdata[0] & ~busy;
                AW'(OFF_IRQ):  if (wdata[0]) reg_d.irq = 1'b0;
                default: ;
            endcase
        end
        if (done) begin
            reg_d.irq       = 1'b1;
            reg_d.code      = done_status;
            reg_d.nonposted = done_kind[3];
            if (done_timeout)
                reg_d.rdat = '1;
            else if (!done_kind[1])
                reg_d.rdat = done_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        case (addr)
            AW'(OFF_CTRL): rdata = reg_q.ctrl;
            AW'(OFF_STAT): rdata = {{(DW-10){1'b0}}, reg_q.code, 6'd0, reg_q.nonposted};
            AW'(OFF_ADLO): rdata = reg_q.adlo;
            AW'(OFF_ADHI): rdata = reg_q.adhi;
            AW'(OFF_WDAT): rdata = reg_q.wdat;
            AW'(OFF_STRB): rdata = {{(DW-SW){1'b0}}, reg_q.strb};
            AW'(OFF_RDAT): rdata = reg_q.rdat;
            AW'(OFF_GO):   rdata = {{(DW-1){1'b0}}, busy};
            AW'(OFF_IRQ):  rdata = {{(DW-1){1'b0}}, reg_q.irq};
            default:       rdata = '0;
        endcase
    end

    assign shadow.kind   = reg_q.ctrl[3:0];
    assign shadow.bypass = reg_q.ctrl[BYPASS_BIT];
    assign shadow.addr   = {reg_q.adhi, reg_q.adlo};
    assign shadow.wdata  = reg_q.wdat;
    assign shadow.strb   = reg_q.strb;

    p_irq_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> reg_q.irq);
    p_abort_on_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_timeout) |=> (reg_q.code == CODE_ABORT && reg_q.rdat == '1));
endmodule

// File: rtl/cfgpio_seq.sv
module cfgpio_seq
    import cfgpio_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024,
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  cfg_req_t      shadow,
    input  logic          req_ready,
    input  logic          cpl_valid,
    input  logic [2:0]    cpl_status,
    input  logic [DW-1:0] cpl_data,
    output logic          busy,
    output logic          req_valid,
    output cfg_req_t      req,
    output logic          done,
    output logic          done_timeout,
    output logic [2:0]    done_status,
    output logic [DW-1:0] done_data,
    output logic [3:0]    done_kind
);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        seq_state_e st;
        cfg_req_t   held;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        done         = 1'b0;
        done_timeout = 1'b0;
        done_status  = cpl_status;
        done_data    = cpl_data;
        case (seq_q.st)
            S_IDLE: begin
                if (go) begin
                    seq_d.st   = S_REQ;
                    seq_d.held = shadow;
                    seq_d.cnt  = '0;
                end
            end
            default: begin
                if (seq_q.st == S_WAIT && cpl_valid) begin
                    done     = 1'b1;
                    seq_d.st = S_IDLE;
                end else if (seq_q.cnt == LAST) begin
                    done         = 1'b1;
                    done_timeout = 1'b1;
                    done_status  = CODE_ABORT;
                    done_data    = '1;
                    seq_d.st     = S_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    if (seq_q.st == S_REQ && req_ready) seq_d.st = S_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, held: '0, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.st != S_IDLE);
    assign req_valid = (seq_q.st == S_REQ);
    assign req       = seq_q.held;
    assign done_kind = seq_q.held.kind;

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !done) |=> (req_valid && $stable(req)));
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !done) |=> !req_valid);
    p_held_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(req)));
    p_window_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (seq_q.cnt <= LAST));
endmodule

// File: rtl/cfgpio_engine.sv
module cfgpio_engine
    import cfgpio_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [3:0]    req_type,
    output logic          req_win_bypass,
    output logic [63:0]   req_addr,
    output logic [31:0]   req_wdata,
    output logic [3:0]    req_strb,
    input  logic          cpl_valid,
    input  logic [2:0]    cpl_status,
    input  logic [31:0]   cpl_data
);
    logic          go, busy, done, done_timeout;
    logic [2:0]    done_status;
    logic [DW-1:0] done_data;
    logic [3:0]    done_kind;
    cfg_req_t      shadow, req;

    cfgpio_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done(done),
        .done_timeout(done_timeout), .done_status(done_status),
        .done_data(done_data), .done_kind(done_kind), .go(go), .shadow(shadow)
    );

    cfgpio_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .shadow(shadow),
        .req_ready(req_ready), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_data(cpl_data), .busy(busy), .req_valid(req_valid), .req(req),
        .done(done), .done_timeout(done_timeout), .done_status(done_status),
        .done_data(done_data), .done_kind(done_kind)
    );

    assign req_type       = req.kind;
    assign req_win_bypass = req.bypass;
    assign req_addr       = req.addr;
    assign req_wdata      = req.wdata;
    assign req_strb       = req.strb;
endmodule

// File: tb/tb_cfgpio_engine.sv
module tb_cfgpio_engine;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [3:0]  req_type;
    logic        req_win_bypass;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    cfgpio_engine #(.TIMEOUT_CYCLES(T)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_type(req_type), .req_win_bypass(req_win_bypass),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] pack_cfg(input int bus, input int dev, input int fn, input int off);
        return ((bus & 'hff) << 20) | ((dev & 'h1f) << 15) | ((fn & 7) << 12) | (off & 'hffc);
    endfunction

    function automatic logic [3:0] strobe(input int size, input int off);
        return 4'(((1 << size) - 1) << (off & 3));
    endfunction

    task automatic accept_and_complete(input logic [2:0] st, input logic [31:0] d);
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        #1;
        chk("R4 valid drops after handshake", req_valid, 0);
        @(negedge clk); cpl_valid = 1'b1; cpl_status = st; cpl_data = d;
        @(negedge clk); cpl_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 8; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset req_valid", req_valid, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(0, 32'h0100_0009); rd(0, v); chk("R2 ctrl", v, 32'h0100_0009);
        wr(2, 32'hA5A5_1234); rd(2, v); chk("R2 addr lo", v, 32'hA5A5_1234);
        wr(3, 32'h0000_0007); rd(3, v); chk("R2 addr hi", v, 32'h7);
        wr(4, 32'hDEAD_BEEF); rd(4, v); chk("R2 wdata", v, 32'hDEAD_BEEF);
        wr(5, 32'hFFFF_FFF6); rd(5, v); chk("R2 strobe", v, 32'h6);
    endtask

    task automatic t_cfg_read();
        logic [31:0] v, a;
        a = pack_cfg(8'h3C, 5'h15, 3'h5, 'h4E);
        wr(0, 32'h0100_0008); wr(2, a); wr(3, 0); wr(5, 4'hF);
        wr(7, 1);
        chk("R3 req_valid after start", req_valid, 1);
        rd(7, v); chk("R3 start reads busy", v, 1);
        chk("R3 type", req_type, 4'h8);
        chk("R3 bypass", req_win_bypass, 1);
        chk("R12 packed address", req_addr, {32'h0, a});
        chk("R12 bus field", req_addr[27:20], 8'h3C);
        chk("R3 strobe", req_strb, 4'hF);
        tick(); tick(); tick();
        chk("R4 held while not ready", req_valid, 1);
        chk("R4 addr stable", req_addr, {32'h0, a});
        cpl_valid = 1'b1; cpl_status = 3'd2; cpl_data = 32'h1111_1111;
        tick();
        cpl_valid = 1'b0;
        chk("R11 cpl before accept ignored", req_valid, 1);
        rd(8, v); chk("R11 irq untouched", v, 0);
        accept_and_complete(3'd0, 32'h8877_6655);
        rd(7, v); chk("R6 start cleared", v, 0);
        rd(8, v); chk("R6 irq set", v, 1);
        rd(1, v); chk("R6 status ok", v[9:7], 0);
        chk("R8 non-posted flag", v[0], 1);
        rd(6, v); chk("R7 read data", v, 32'h8877_6655);
        chk("R12 byte extract off 2", (v >> 16) & 'hff, 32'h77);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        wr(8, 0); rd(8, v); chk("R10 write 0 keeps irq", v, 1);
        wr(8, 1); rd(8, v); chk("R10 write 1 clears irq", v, 0);
    endtask

    task automatic t_cfg_write_busy();
        logic [31:0] v, a;
        a = pack_cfg(1, 2, 3, 'h11);
        wr(0, 32'h0000_000B); wr(2, a); wr(4, 32'hAB << 8); wr(5, strobe(1, 1));
        wr(7, 1);
        chk("R12 write data shifted", req_wdata, 32'h0000_AB00);
        chk("R12 write strobe", req_strb, 4'b0010);
        chk("R3 bypass off", req_win_bypass, 0);
        wr(2, 32'h0BAD_0000); wr(0, 32'h8); wr(7, 1);
        chk("R5 addr kept in flight", req_addr, {32'h0, a});
        chk("R5 type kept in flight", req_type, 4'hB);
        accept_and_complete(3'd1, 32'h5555_AAAA);
        rd(1, v); chk("R6 status unsupported", v[9:7], 1);
        rd(6, v); chk("R7 write keeps read data", v, 32'h8877_6655);
        tick(); tick();
        chk("R5 no second request", req_valid, 0);
        rd(7, v); chk("R5 idle after one transfer", v, 0);
        wr(8, 1);
    endtask

    task automatic t_posted_flag();
        logic [31:0] v;
        wr(0, 32'h2); wr(7, 1);
        accept_and_complete(3'd4, 0);
        rd(1, v); chk("R8 posted flag clear", v[0], 0);
        chk("R6 status abort code", v[9:7], 4);
        wr(8, 1);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        wr(0, 32'h9); wr(7, 1);
        for (int i = 0; i < T - 1; i++) tick();
        chk("R9 still waiting before limit", req_valid, 1);
        tick();
        chk("R9 request withdrawn", req_valid, 0);
        rd(7, v); chk("R9 start cleared", v, 0);
        rd(1, v); chk("R9 abort status", v[9:7], 4);
        rd(6, v); chk("R9 all-ones data", v, 32'hFFFF_FFFF);
        rd(8, v); chk("R9 irq set", v, 1);
        wr(8, 1);
        cpl_valid = 1'b1; cpl_status = 3'd1; cpl_data = 0;
        tick();
        cpl_valid = 1'b0;
        rd(8, v); chk("R11 idle cpl ignored irq", v, 0);
        rd(6, v); chk("R11 idle cpl ignored data", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_readback();
        t_cfg_read();
        t_irq_clear();
        t_cfg_write_busy();
        t_posted_flag();
        t_timeout();
        summary();
    end
endmodule